// File: doc/BRIEF.md
# Interrupt Event Register Group

This block collects single-cycle event pulses from an I2C transfer sequencer into a sticky status register and turns them into one level-sensitive interrupt line. Every register in the group shares one 10-bit event layout: completion (bit 0), data (1), NACK (2), timeout (3), target ready (4), receive overflow (5), transmit overflow (6), receive underflow (7) and arbitration lost (9). Bit 8 is reserved.

Software reaches the group over a simple memory-mapped bus with word offsets.

| Offset | Register | Access |
|---|---|---|
| 0 | status | read, write-one-to-clear |
| 1 | mask | read only; 1 means masked |
| 2 | unmask | write only; each 1 unmasks that event |
| 3 | set-mask | write only; each 1 masks that event |

A status bit captures its event even while the event is masked. The mask gates only the interrupt line. A second output reports whether any error-class event is pending. The error class is NACK, both overflows, receive underflow and arbitration lost.

Top module: `irq_event_regs`

## Requirements
- R1: After reset, status reads 0, mask reads 0x2FF (all implemented events masked), and both irq and err_pend are low.
- R2: A pulse on evt_pulse bit i (i in 0..7 or 9) sets status bit i on the next clock edge, whatever the mask bit is.
- R3: Bit 8 is reserved: it reads 0 at offsets 0 and 1, and an event pulse on bit 8 never sets anything.
- R4: A write to offset 2 clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: A write to offset 3 sets each implemented mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R6: A write to offset 0 clears each status bit whose write-data bit is 1. Status bits written with 0 are unchanged.
- R7: When an event pulse and a clearing write to offset 0 hit the same status bit in the same cycle, the bit ends up set.
- R8: irq is high exactly when some status bit is set and its mask bit is 0. It stays high until those status bits are cleared or masked.
- R9: err_pend is high exactly when any of status bits 2, 5, 6, 7 or 9 is set, independent of the mask.
- R10: A write to offset 1 has no effect on the mask register.
- R11: Reads at offsets 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_pulse | input | EVT_W (10) | One-cycle event pulses from the transfer sequencer |
| bus_sel | input | 1 | Bus access strobe; one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (2) | Word offset of the register |
| bus_wdata | input | EVT_W (10) | Write data in event layout |
| bus_rdata | output | DATA_W (32) | Combinational read data; zero when no read is selected |
| irq | output | 1 | Level interrupt: any unmasked status bit set |
| err_pend | output | 1 | Any error-class status bit set |

## Verification
The bench uses the default configuration: a 10-bit event layout, 2-bit offsets and a 32-bit read bus. This is small enough to sweep all 1024 event patterns. For each pattern it applies a different unmask pattern and a different partial clear pattern, so every combination of status, mask and clear bit is covered, including the reserved bit. Directed sequences add the cases a sweep cannot reach: an event colliding with its own clear, writes to the read-only mask offset, reads of the write-only offsets, and masking an interrupt that is already pending.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int EVT_W = 10;

  // Implemented event positions (bit 8 reserved)
  localparam logic [EVT_W-1:0] EVT_VALID = 10'h2FF;
  // Error class: NACK(2), RX overflow(5), TX overflow(6), RX underflow(7), arbitration lost(9)
  localparam logic [EVT_W-1:0] EVT_ERR   = 10'h2E4;

  typedef enum logic [1:0] {
    OFS_STATUS = 2'd0,
    OFS_MASK   = 2'd1,
    OFS_UNMASK = 2'd2,
    OFS_SETMSK = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [EVT_W-1:0]  status_q,
  input  logic [EVT_W-1:0]  mask_q,
  output logic              w1c_hit,
  output logic              unmask_hit,
  output logic              setmsk_hit,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - EVT_W;

  logic             wr_acc;
  logic             rd_acc;
  logic [EVT_W-1:0] rd_val;

  assign wr_acc = bus_sel &  bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  always_comb begin
    w1c_hit    = 1'b0;
    unmask_hit = 1'b0;
    setmsk_hit = 1'b0;
    rd_val     = '0;
    case (bus_addr)
      ADDR_W'(OFS_STATUS): begin
        w1c_hit = wr_acc;
        if (rd_acc) rd_val = status_q;
      end
      ADDR_W'(OFS_MASK): begin
        if (rd_acc) rd_val = mask_q;
      end
      ADDR_W'(OFS_UNMASK): unmask_hit = wr_acc;
      ADDR_W'(OFS_SETMSK): setmsk_hit = wr_acc;
      default: ;
    endcase
  end

  assign rd_data = {{PAD_W{1'b0}}, rd_val};
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic             w1c_hit,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] status_q
);
  logic [EVT_W-1:0] set_v;
  logic [EVT_W-1:0] clr_v;
  logic [EVT_W-1:0] status_d;
  logic [EVT_W-1:0] bit_en;

  always_comb begin
    set_v    = evt_pulse & EVT_VALID;
    clr_v    = wdata & {EVT_W{w1c_hit}};
    // a new event wins over a simultaneous clear
    status_d = (set_v | (status_q & ~clr_v)) & EVT_VALID;
    bit_en   = set_v | clr_v;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status_q[i] <= 1'b0;
      else if (bit_en[i]) status_q[i] <= status_d[i];
    end
  end

  assert_evt_sets_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status_q & $past(evt_pulse & EVT_VALID)) == $past(evt_pulse & EVT_VALID)));

  assert_status_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !w1c_hit |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unmask_hit,
  input  logic             setmsk_hit,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] mask_q
);
  logic [EVT_W-1:0] mask_d;
  logic             mask_en;

  always_comb begin
    mask_en = unmask_hit | setmsk_hit;
    mask_d  = mask_q;
    if (setmsk_hit) mask_d = mask_d | wdata;
    if (unmask_hit) mask_d = mask_d & ~wdata;
    mask_d  = mask_d & EVT_VALID;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q[i] <= EVT_VALID[i];
      else if (mask_en) mask_q[i] <= mask_d[i];
    end
  end

  assert_unmask_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_hit |=> ((mask_q & $past(wdata)) == '0));

  assert_setmask_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (setmsk_hit && !unmask_hit) |=>
      ((mask_q & $past(wdata & EVT_VALID)) == $past(wdata & EVT_VALID)));
endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
  import irq_regs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [EVT_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              err_pend
);
  logic             rst_s1;
  logic             rst_sync_n;
  logic [EVT_W-1:0] status_q;
  logic [EVT_W-1:0] mask_q;
  logic             w1c_hit;
  logic             unmask_hit;
  logic             setmsk_hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  irq_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .w1c_hit    (w1c_hit),
    .unmask_hit (unmask_hit),
    .setmsk_hit (setmsk_hit),
    .rd_data    (bus_rdata)
  );

  irq_status_bank u_stat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_pulse (evt_pulse),
    .w1c_hit   (w1c_hit),
    .wdata     (bus_wdata),
    .status_q  (status_q)
  );

  irq_mask_bank u_mask (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .unmask_hit (unmask_hit),
    .setmsk_hit (setmsk_hit),
    .wdata      (bus_wdata),
    .mask_q     (mask_q)
  );

  assign irq      = |(status_q & ~mask_q);
  assign err_pend = |(status_q & EVT_ERR);

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !(bus_sel && bus_wr)) |=> irq);
endmodule

// File: tb/tb_irq_event_regs.sv
module tb_irq_event_regs;
  localparam int EW = 10;
  localparam logic [EW-1:0] VALID = 10'h2FF;
  localparam logic [EW-1:0] ERR   = 10'h2E4;

  logic          clk;
  logic          rst_n;
  logic [EW-1:0] evt_pulse;
  logic          bus_sel;
  logic          bus_wr;
  logic [1:0]    bus_addr;
  logic [EW-1:0] bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq;
  logic          err_pend;

  int checks;
  int failures;
  int cycles;

  irq_event_regs dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .err_pend(err_pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [EW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [EW-1:0] p);
    @(negedge clk);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    logic [EW-1:0] e, c, st, mk;
    checks = 0; failures = 0;
    rst_n = 1'b0; evt_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, r); check("R1 status", r, 32'h0);
    rd(2'd1, r); check("R1 mask", r, 32'h2FF);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 err_pend", {31'b0, err_pend}, 32'h0);

    // R11 write-only offsets read zero
    rd(2'd2, r); check("R11 read ofs2", r, 32'h0);
    rd(2'd3, r); check("R11 read ofs3", r, 32'h0);

    // R10 mask offset is read-only
    wr(2'd1, 10'h000);
    rd(2'd1, r); check("R10 mask after write", r, 32'h2FF);

    // R3 reserved bit
    pulse(10'h100);
    rd(2'd0, r); check("R3 reserved status", r, 32'h0);
    wr(2'd2, 10'h3FF);
    rd(2'd1, r); check("R3 mask all unmasked", r, 32'h0);
    wr(2'd3, 10'h100);
    rd(2'd1, r); check("R3 reserved mask", r, 32'h0);

    // R5 partial set-mask
    wr(2'd3, 10'h005);
    rd(2'd1, r); check("R5 partial setmask", r, 32'h005);
    wr(2'd3, 10'h200);
    rd(2'd1, r); check("R5 setmask keeps others", r, 32'h205);

    // R2 masked event still captured; R8 no irq while masked
    pulse(10'h001);
    rd(2'd0, r); check("R2 masked event captured", r, 32'h1);
    check("R8 masked no irq", {31'b0, irq}, 32'h0);
    check("R9 completion not error", {31'b0, err_pend}, 32'h0);
    // R8 unmask pending event raises irq; holds through idle
    wr(2'd2, 10'h001);
    check("R8 irq after unmask", {31'b0, irq}, 32'h1);
    repeat (5) @(negedge clk);
    check("R8 irq holds", {31'b0, irq}, 32'h1);
    wr(2'd3, 10'h001);
    check("R8 irq drops when masked", {31'b0, irq}, 32'h0);
    rd(2'd0, r); check("R8 status kept when masked", r, 32'h1);
    wr(2'd0, 10'h3FF);

    // R7 event collides with clear
    pulse(10'h044);
    @(negedge clk);
    evt_pulse = 10'h004;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 10'h3FF;
    @(negedge clk);
    evt_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(2'd0, r); check("R7 collision keeps bit", r, 32'h004);
    wr(2'd0, 10'h3FF);

    // Sweep all event patterns
    for (int p = 0; p < 1024; p++) begin
      e = EW'((p * 37 + 5) & 10'h3FF);
      c = EW'((p * 11) & 10'h3FF);
      wr(2'd3, 10'h3FF);
      wr(2'd2, e);
      mk = VALID & ~e;
      rd(2'd1, r); check("R4 unmask sweep", r, {22'b0, mk});
      pulse(EW'(p));
      st = EW'(p) & VALID;
      rd(2'd0, r); check("R2 R3 status sweep", r, {22'b0, st});
      check("R9 err sweep", {31'b0, err_pend}, {31'b0, |(st & ERR)});
      check("R8 irq sweep", {31'b0, irq}, {31'b0, |(st & ~mk)});
      wr(2'd0, c);
      st = st & ~c;
      rd(2'd0, r); check("R6 partial clear sweep", r, {22'b0, st});
      check("R8 irq after clear", {31'b0, irq}, {31'b0, |(st & ~mk)});
      wr(2'd0, 10'h3FF);
      rd(2'd0, r); check("R6 full clear sweep", r, 32'h0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule